// File: doc/BRIEF.md
# Set-Associative Cache Controller

This block is a cache placed between a processor port that moves one word at a time and a memory port that moves a whole block. Parameters set the number of sets, the number of ways per set and the number of words per block. A value of one way gives a direct-mapped cache. The address is split into three fields: the offset in the low bits, the set index in the middle bits and the tag in the high bits. On each request the block compares the tag against every valid way of the indexed set in parallel. A hit is answered in the same cycle. A miss starts a short state machine that writes back a dirty victim if needed, fetches the block, and then answers.

A compile-time parameter picks one of two write policies. In the first, a write marks the cached line dirty and memory is only written when that line is evicted; write misses allocate the line. In the second, every write goes straight to memory, and only a line that is already cached is updated; write misses do not allocate. When a set is full, the least recently used way is replaced. Two free-running counters record hits and misses so that the hit/miss pattern of an access trace can be observed.

Top module: `cache_ctrl`

## Requirements
- R1: Address fields are offset in bits [OFF_W-1:0], set index in the next IDX_W bits, and tag in the remaining high bits. Blocks at consecutive block addresses therefore map to different sets and can be resident at the same time.
- R2: A read that hits (a way of the indexed set is valid and its tag matches) raises cpu_ready in the same cycle as cpu_req and returns the stored word at the offset. cpu_ready is never high without cpu_req.
- R3: A read miss holds cpu_ready low and issues one block read at the block-aligned address (offset bits zero). It then returns the requested word, with cpu_ready high in the cycle after the read is acknowledged.
- R4: A direct-mapped configuration with 4-bit addresses, 4 sets and 2 words per block gives miss, hit, miss, miss, miss for the read trace 0, 1, 13, 8, 0. Address 8 evicts the block of address 0.
- R5: A miss fills the lowest-numbered invalid way of the set if there is one; otherwise it replaces the least recently used way. Hits and fills both update recency. At most one way of a set ever matches.
- R6: In write-back mode a write hit completes in one cycle with no memory traffic and marks the line dirty. Evicting a dirty line writes the whole block to memory (all strobe bits set) before the fill read is issued. Evicting a clean line causes no write.
- R7: In write-back mode a write miss first loads the block and then merges the written word into it. The line is then dirty, and memory is unchanged.
- R8: In write-through mode a write hit updates the cached word and writes that word to memory. The write uses a single strobe bit, bit number equal to the offset, and the other words of the block are untouched.
- R9: In write-through mode a write miss writes the word to memory only. No block is read and no line is allocated, so a following read of that address misses.
- R10: Reset clears every valid and dirty bit and zeroes both counters. After reset every access misses.
- R11: Each accepted request increments exactly one of hit_cnt or miss_cnt, and both counters stay unchanged in cycles with no new request.
- R12: mem_req stays high with stable mem_addr and mem_we until mem_ack. mem_ack is a one-cycle pulse, and each miss performs exactly one block read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req | input | 1 | Request valid, held until cpu_ready |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | ADDR_W | Word address |
| cpu_wdata | input | DATA_W | Write word |
| cpu_rdata | output | DATA_W | Read word, valid with cpu_ready |
| cpu_ready | output | 1 | Access completes at this clock edge |
| mem_req | output | 1 | Memory transfer request |
| mem_we | output | 1 | 1 = memory write, 0 = block read |
| mem_addr | output | ADDR_W | Block-aligned memory address |
| mem_wdata | output | BLK_WORDS*DATA_W | Block write data, word j in bits j*DATA_W |
| mem_wstrb | output | BLK_WORDS | Per-word write enables |
| mem_ack | input | 1 | One-cycle completion of the memory transfer |
| mem_rdata | input | BLK_WORDS*DATA_W | Block read data, valid with mem_ack |
| hit_cnt | output | CNT_W | Hit counter |
| miss_cnt | output | CNT_W | Miss counter |

## Verification
A wrong valid or tag bit shows up on the very next access to that set: the hit counter and ready timing disagree with the expected hit/miss pattern, or a stale word appears on cpu_rdata in the same cycle. Corrupted recency state does not show at once. It appears only when a full set next misses, as a later miss on a line that should have stayed resident. A lost dirty bit is hidden until eviction, so the bench forces evictions and then inspects the memory model. Write-through strobe errors are visible in memory right after the acknowledge.

// File: rtl/cache_pkg.sv
package cache_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_WBACK = 3'd1,
    ST_FILL  = 3'd2,
    ST_WTWR  = 3'd3,
    ST_RESP  = 3'd4
  } cache_st_e;
endpackage

// File: rtl/cache_lookup.sv
module cache_lookup #(
  parameter int WAYS  = 2,
  parameter int TAG_W = 4,
  parameter int WAY_W = 1
) (
  input  logic [WAYS-1:0]       valid_row,
  input  logic [WAYS*TAG_W-1:0] tag_row,
  input  logic [TAG_W-1:0]      req_tag,
  input  logic [WAY_W-1:0]      lru_way,
  output logic [WAYS-1:0]       match_vec,
  output logic                  hit,
  output logic [WAY_W-1:0]      hit_way,
  output logic [WAY_W-1:0]      victim_way
);
  // one comparator per way, all in parallel
  for (genvar g = 0; g < WAYS; g++) begin : g_cmp
    assign match_vec[g] = valid_row[g] && (tag_row[g*TAG_W +: TAG_W] == req_tag);
  end

  assign hit = |match_vec;

  always_comb begin
    hit_way = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (match_vec[w]) hit_way = WAY_W'(w);
    end
  end

  // lowest invalid way wins, otherwise the recency choice
  always_comb begin
    victim_way = lru_way;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (!valid_row[w]) victim_way = WAY_W'(w);
    end
  end
endmodule

// File: rtl/cache_lru.sv
module cache_lru #(
  parameter int SETS  = 4,
  parameter int WAYS  = 2,
  parameter int WAY_W = 1,
  parameter int IDX_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             touch_en,
  input  logic [IDX_W-1:0] touch_idx,
  input  logic [WAY_W-1:0] touch_way,
  input  logic [IDX_W-1:0] look_idx,
  output logic [WAY_W-1:0] lru_way
);
  if (WAYS == 1) begin : g_direct
    assign lru_way = '0;
  end else begin : g_age
    // age 0 = most recent, WAYS-1 = least recent
    logic [WAY_W-1:0] age_q [SETS][WAYS];
    logic [WAY_W-1:0] row_d [WAYS];
    logic [WAY_W-1:0] ref_age;

    always_comb begin
      ref_age = age_q[touch_idx][touch_way];
      for (int w = 0; w < WAYS; w++) begin
        if (WAY_W'(w) == touch_way)
          row_d[w] = '0;
        else if (age_q[touch_idx][w] < ref_age)
          row_d[w] = age_q[touch_idx][w] + WAY_W'(1);
        else
          row_d[w] = age_q[touch_idx][w];
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        for (int s = 0; s < SETS; s++)
          for (int w = 0; w < WAYS; w++)
            age_q[s][w] <= WAY_W'(w);
      end else if (touch_en) begin
        for (int w = 0; w < WAYS; w++)
          age_q[touch_idx][w] <= row_d[w];
      end
    end

    always_comb begin
      lru_way = '0;
      for (int w = 0; w < WAYS; w++) begin
        if (age_q[look_idx][w] == WAY_W'(WAYS - 1)) lru_way = WAY_W'(w);
      end
    end

    // R5: the ages of a touched set keep one entry at the oldest value
    a_r5_one_oldest: assert property (@(posedge clk) disable iff (!rst_n)
      touch_en |=> ($countones({age_q[touch_idx][0] == WAY_W'(WAYS - 1),
                                age_q[touch_idx][WAYS-1] == WAY_W'(WAYS - 1)}) <= 1));
  end
endmodule

// File: rtl/cache_ctrl.sv
module cache_ctrl
  import cache_pkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter int DATA_W     = 8,
  parameter int SETS       = 4,
  parameter int WAYS       = 2,
  parameter int BLK_WORDS  = 2,
  parameter bit WRITE_BACK = 1'b1,
  parameter int CNT_W      = 16
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          cpu_req,
  input  logic                          cpu_we,
  input  logic [ADDR_W-1:0]             cpu_addr,
  input  logic [DATA_W-1:0]             cpu_wdata,
  output logic [DATA_W-1:0]             cpu_rdata,
  output logic                          cpu_ready,
  output logic                          mem_req,
  output logic                          mem_we,
  output logic [ADDR_W-1:0]             mem_addr,
  output logic [BLK_WORDS*DATA_W-1:0]   mem_wdata,
  output logic [BLK_WORDS-1:0]          mem_wstrb,
  input  logic                          mem_ack,
  input  logic [BLK_WORDS*DATA_W-1:0]   mem_rdata,
  output logic [CNT_W-1:0]              hit_cnt,
  output logic [CNT_W-1:0]              miss_cnt
);
  localparam int OFF_W = $clog2(BLK_WORDS);
  localparam int IDX_W = $clog2(SETS);
  localparam int TAG_W = ADDR_W - IDX_W - OFF_W;
  localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1;
  localparam int BLK_W = BLK_WORDS * DATA_W;

  // storage
  logic              valid_q [SETS][WAYS];
  logic              dirty_q [SETS][WAYS];
  logic [TAG_W-1:0]  tag_q   [SETS][WAYS];
  logic [DATA_W-1:0] data_q  [SETS][WAYS][BLK_WORDS];

  // request fields
  logic [TAG_W-1:0] cur_tag;
  logic [IDX_W-1:0] cur_idx;
  logic [OFF_W-1:0] cur_off;
  assign cur_tag = cpu_addr[ADDR_W-1 -: TAG_W];
  assign cur_idx = cpu_addr[OFF_W +: IDX_W];
  assign cur_off = cpu_addr[OFF_W-1:0];

  // latched request for the miss path
  logic [TAG_W-1:0]  rq_tag;
  logic [IDX_W-1:0]  rq_idx;
  logic [OFF_W-1:0]  rq_off;
  logic              rq_we;
  logic [DATA_W-1:0] rq_wdata;
  logic [WAY_W-1:0]  way_q;

  cache_st_e st_q, st_d;

  // lookup
  logic [WAYS-1:0]       valid_row;
  logic [WAYS*TAG_W-1:0] tag_row;
  logic [WAYS-1:0]       match_vec;
  logic                  hit;
  logic [WAY_W-1:0]      hit_way, victim_way, lru_way;

  always_comb begin
    for (int w = 0; w < WAYS; w++) begin
      valid_row[w]                = valid_q[cur_idx][w];
      tag_row[w*TAG_W +: TAG_W]   = tag_q[cur_idx][w];
    end
  end

  cache_lookup #(.WAYS(WAYS), .TAG_W(TAG_W), .WAY_W(WAY_W)) u_lookup (
    .valid_row  (valid_row),
    .tag_row    (tag_row),
    .req_tag    (cur_tag),
    .lru_way    (lru_way),
    .match_vec  (match_vec),
    .hit        (hit),
    .hit_way    (hit_way),
    .victim_way (victim_way)
  );

  // control strobes
  logic accept, hit_fire, wr_hit, fill_en, wt_write, vic_dirty, touch_en;
  logic [IDX_W-1:0] touch_idx;
  logic [WAY_W-1:0] touch_way;

  assign accept    = (st_q == ST_IDLE) && cpu_req;
  assign hit_fire  = accept && hit;
  assign wr_hit    = hit_fire && cpu_we;
  assign wt_write  = cpu_we && !WRITE_BACK;
  assign fill_en   = (st_q == ST_FILL) && mem_ack;
  assign vic_dirty = valid_q[cur_idx][victim_way] && dirty_q[cur_idx][victim_way];
  assign touch_en  = hit_fire || fill_en;
  assign touch_idx = fill_en ? rq_idx : cur_idx;
  assign touch_way = fill_en ? way_q : hit_way;

  cache_lru #(.SETS(SETS), .WAYS(WAYS), .WAY_W(WAY_W), .IDX_W(IDX_W)) u_lru (
    .clk       (clk),
    .rst_n     (rst_n),
    .touch_en  (touch_en),
    .touch_idx (touch_idx),
    .touch_way (touch_way),
    .look_idx  (cur_idx),
    .lru_way   (lru_way)
  );

  // next state
  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE: begin
        if (cpu_req) begin
          if (wt_write)       st_d = ST_WTWR;
          else if (!hit)      st_d = vic_dirty ? ST_WBACK : ST_FILL;
        end
      end
      ST_WBACK: if (mem_ack) st_d = ST_FILL;
      ST_FILL:  if (mem_ack) st_d = ST_RESP;
      ST_WTWR:  if (mem_ack) st_d = ST_RESP;
      ST_RESP:  st_d = ST_IDLE;
      default:  st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end

  // request capture, enabled only on acceptance
  always_ff @(posedge clk) begin
    if (accept) begin
      rq_tag   <= cur_tag;
      rq_idx   <= cur_idx;
      rq_off   <= cur_off;
      rq_we    <= cpu_we;
      rq_wdata <= cpu_wdata;
      way_q    <= hit ? hit_way : victim_way;
    end
  end

  // valid and dirty bits
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++)
        for (int w = 0; w < WAYS; w++) begin
          valid_q[s][w] <= 1'b0;
          dirty_q[s][w] <= 1'b0;
        end
    end else if (fill_en) begin
      valid_q[rq_idx][way_q] <= 1'b1;
      dirty_q[rq_idx][way_q] <= rq_we;
    end else if (wr_hit && WRITE_BACK) begin
      dirty_q[cur_idx][hit_way] <= 1'b1;
    end
  end

  // tag and data arrays
  always_ff @(posedge clk) begin
    if (fill_en) begin
      tag_q[rq_idx][way_q] <= rq_tag;
      for (int j = 0; j < BLK_WORDS; j++)
        data_q[rq_idx][way_q][j] <= (rq_we && rq_off == OFF_W'(j)) ?
                                    rq_wdata : mem_rdata[j*DATA_W +: DATA_W];
    end else if (wr_hit) begin
      data_q[cur_idx][hit_way][cur_off] <= cpu_wdata;
    end
  end

  // processor side
  assign cpu_ready = (hit_fire && !wt_write) || (st_q == ST_RESP);
  assign cpu_rdata = (st_q == ST_IDLE) ? data_q[cur_idx][hit_way][cur_off]
                                       : data_q[rq_idx][way_q][rq_off];

  // memory side
  logic [BLK_W-1:0] vic_block;
  always_comb begin
    for (int j = 0; j < BLK_WORDS; j++)
      vic_block[j*DATA_W +: DATA_W] = data_q[rq_idx][way_q][j];
  end

  always_comb begin
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = {rq_tag, rq_idx, {OFF_W{1'b0}}};
    mem_wdata = '0;
    mem_wstrb = '0;
    unique case (st_q)
      ST_WBACK: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = {tag_q[rq_idx][way_q], rq_idx, {OFF_W{1'b0}}};
        mem_wdata = vic_block;
        mem_wstrb = '1;
      end
      ST_FILL: mem_req = 1'b1;
      ST_WTWR: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_wdata = {BLK_WORDS{rq_wdata}};
        mem_wstrb = BLK_WORDS'(1) << rq_off;
      end
      default: ;
    endcase
  end

  // counters
  logic [CNT_W-1:0] hit_cnt_q, miss_cnt_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hit_cnt_q  <= '0;
      miss_cnt_q <= '0;
    end else if (accept) begin
      if (hit) hit_cnt_q  <= hit_cnt_q + CNT_W'(1);
      else     miss_cnt_q <= miss_cnt_q + CNT_W'(1);
    end
  end
  assign hit_cnt  = hit_cnt_q;
  assign miss_cnt = miss_cnt_q;

  // assertions
  a_r2_ready_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ready |-> cpu_req);

  a_r3_fill_then_ready: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_q == ST_FILL) && mem_ack) |=> cpu_ready);

  a_r5_single_match: assert property (@(posedge clk) disable iff (!rst_n)
    accept |-> $onehot0(match_vec));

  a_r6_wb_before_fill: assert property (@(posedge clk) disable iff (!rst_n)
    (WRITE_BACK && mem_req && mem_we && mem_ack) |=> (mem_req && !mem_we));

  a_r8_wt_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    (!WRITE_BACK && mem_req && mem_we) |-> $onehot(mem_wstrb));

  a_r11_cnt_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !accept |=> ($stable(hit_cnt) && $stable(miss_cnt)));

  a_r12_req_held: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));
endmodule

// File: tb/cache_ctrl_tb.sv
module cache_tb_mem #(
  parameter int AW = 8,
  parameter int DW = 8,
  parameter int BW = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req,
  input  logic             we,
  input  logic [AW-1:0]    addr,
  input  logic [BW*DW-1:0] wdata,
  input  logic [BW-1:0]    wstrb,
  output logic             ack,
  output logic [BW*DW-1:0] rdata
);
  logic [DW-1:0] mem [2**AW];
  int rd_cnt = 0;
  int wr_cnt = 0;
  int dly;

  initial for (int a = 0; a < 2**AW; a++) mem[a] = DW'(a) ^ DW'(8'hA5);

  always @(posedge clk) begin
    if (!rst_n) begin
      ack <= 1'b0;
      dly <= 0;
    end else begin
      ack <= 1'b0;
      if (req && !ack) begin
        if (dly == 2) begin
          ack <= 1'b1;
          dly <= 0;
          if (we) begin
            for (int j = 0; j < BW; j++)
              if (wstrb[j]) mem[int'(addr) + j] <= wdata[j*DW +: DW];
            wr_cnt <= wr_cnt + 1;
          end else begin
            for (int j = 0; j < BW; j++)
              rdata[j*DW +: DW] <= mem[int'(addr) + j];
            rd_cnt <= rd_cnt + 1;
          end
        end else begin
          dly <= dly + 1;
        end
      end
    end
  end
endmodule

module cache_ctrl_tb;
  localparam int CLK_P = 10;

  logic clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;
  logic rst_n;

  // index 0: write-back 2-way, 1: direct-mapped 4-bit, 2: write-through 2-way
  logic        req   [3];
  logic        we_s  [3];
  logic [7:0]  addr_s[3];
  logic [7:0]  wd_s  [3];
  logic [7:0]  rd_s  [3];
  logic        rdy   [3];
  logic [15:0] hc    [3];
  logic [15:0] mc    [3];

  logic m0_req, m0_we, m0_ack; logic [7:0] m0_addr; logic [15:0] m0_wd, m0_rd; logic [1:0] m0_st;
  logic m1_req, m1_we, m1_ack; logic [3:0] m1_addr; logic [15:0] m1_wd, m1_rd; logic [1:0] m1_st;
  logic m2_req, m2_we, m2_ack; logic [7:0] m2_addr; logic [15:0] m2_wd, m2_rd; logic [1:0] m2_st;

  cache_ctrl #(.ADDR_W(8), .WAYS(2), .WRITE_BACK(1'b1)) u_dut (
    .clk(clk), .rst_n(rst_n), .cpu_req(req[0]), .cpu_we(we_s[0]), .cpu_addr(addr_s[0]),
    .cpu_wdata(wd_s[0]), .cpu_rdata(rd_s[0]), .cpu_ready(rdy[0]),
    .mem_req(m0_req), .mem_we(m0_we), .mem_addr(m0_addr), .mem_wdata(m0_wd),
    .mem_wstrb(m0_st), .mem_ack(m0_ack), .mem_rdata(m0_rd), .hit_cnt(hc[0]), .miss_cnt(mc[0]));
  cache_tb_mem #(.AW(8)) u_mem0 (.clk(clk), .rst_n(rst_n), .req(m0_req), .we(m0_we),
    .addr(m0_addr), .wdata(m0_wd), .wstrb(m0_st), .ack(m0_ack), .rdata(m0_rd));

  cache_ctrl #(.ADDR_W(4), .WAYS(1), .WRITE_BACK(1'b1)) u_dut_dm (
    .clk(clk), .rst_n(rst_n), .cpu_req(req[1]), .cpu_we(we_s[1]), .cpu_addr(addr_s[1][3:0]),
    .cpu_wdata(wd_s[1]), .cpu_rdata(rd_s[1]), .cpu_ready(rdy[1]),
    .mem_req(m1_req), .mem_we(m1_we), .mem_addr(m1_addr), .mem_wdata(m1_wd),
    .mem_wstrb(m1_st), .mem_ack(m1_ack), .mem_rdata(m1_rd), .hit_cnt(hc[1]), .miss_cnt(mc[1]));
  cache_tb_mem #(.AW(4)) u_mem1 (.clk(clk), .rst_n(rst_n), .req(m1_req), .we(m1_we),
    .addr(m1_addr), .wdata(m1_wd), .wstrb(m1_st), .ack(m1_ack), .rdata(m1_rd));

  cache_ctrl #(.ADDR_W(8), .WAYS(2), .WRITE_BACK(1'b0)) u_dut_wt (
    .clk(clk), .rst_n(rst_n), .cpu_req(req[2]), .cpu_we(we_s[2]), .cpu_addr(addr_s[2]),
    .cpu_wdata(wd_s[2]), .cpu_rdata(rd_s[2]), .cpu_ready(rdy[2]),
    .mem_req(m2_req), .mem_we(m2_we), .mem_addr(m2_addr), .mem_wdata(m2_wd),
    .mem_wstrb(m2_st), .mem_ack(m2_ack), .mem_rdata(m2_rd), .hit_cnt(hc[2]), .miss_cnt(mc[2]));
  cache_tb_mem #(.AW(8)) u_mem2 (.clk(clk), .rst_n(rst_n), .req(m2_req), .we(m2_we),
    .addr(m2_addr), .wdata(m2_wd), .wstrb(m2_st), .ack(m2_ack), .rdata(m2_rd));

  int nchk = 0;
  int nfail = 0;
  int exp_h[3] = '{0, 0, 0};
  int exp_m[3] = '{0, 0, 0};

  function automatic int rdc(input int k);
    case (k)
      0: return u_mem0.rd_cnt;
      1: return u_mem1.rd_cnt;
      default: return u_mem2.rd_cnt;
    endcase
  endfunction

  function automatic int wrc(input int k);
    case (k)
      0: return u_mem0.wr_cnt;
      1: return u_mem1.wr_cnt;
      default: return u_mem2.wr_cnt;
    endcase
  endfunction

  function automatic int memv(input int k, input int a);
    case (k)
      0: return int'(u_mem0.mem[a]);
      1: return int'(u_mem1.mem[a]);
      default: return int'(u_mem2.mem[a]);
    endcase
  endfunction

  task automatic check(input string rq, input string what, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  // one processor access; hit/miss judged by the counters, read data optional
  task automatic access(input int k, input logic w, input logic [7:0] a, input logic [7:0] d,
                        input logic exp_hit, input logic chk_rd, input logic [7:0] exp_rd,
                        input string rq);
    int cyc;
    int h0, m0;
    logic [7:0] got;
    h0 = int'(hc[k]);
    m0 = int'(mc[k]);
    @(negedge clk);
    req[k] = 1'b1; we_s[k] = w; addr_s[k] = a; wd_s[k] = d;
    cyc = 0;
    #(CLK_P/4);
    while (!rdy[k] && cyc < 50) begin
      @(negedge clk);
      cyc++;
      #(CLK_P/4);
    end
    got = rd_s[k];
    @(negedge clk);
    req[k] = 1'b0; we_s[k] = 1'b0;
    if (exp_hit) exp_h[k]++; else exp_m[k]++;
    check(rq, $sformatf("hit@%0h", a), int'(hc[k]) - h0, exp_hit ? 1 : 0);
    check(rq, $sformatf("miss@%0h", a), int'(mc[k]) - m0, exp_hit ? 0 : 1);
    if (exp_hit && !w) check("R2", $sformatf("wait cycles@%0h", a), cyc, 0);
    if (!exp_hit && !w) check("R3", $sformatf("ready delayed@%0h", a), int'(cyc > 0), 1);
    if (chk_rd) check(rq, $sformatf("rdata@%0h", a), int'(got), int'(exp_rd));
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic t_reset_state();
    for (int k = 0; k < 3; k++) begin
      check("R10", "hit_cnt after reset", int'(hc[k]), 0);
      check("R10", "miss_cnt after reset", int'(mc[k]), 0);
      check("R2", "ready idle", int'(rdy[k]), 0);
    end
  endtask

  task automatic t_read_miss_hit();
    int r0 = rdc(0);
    access(0, 1'b0, 8'h10, 8'h00, 1'b0, 1'b1, 8'hB5, "R3");
    check("R12", "one block read per miss", rdc(0) - r0, 1);
    access(0, 1'b0, 8'h11, 8'h00, 1'b1, 1'b1, 8'hB4, "R2");
  endtask

  task automatic t_middle_index();
    access(0, 1'b0, 8'h12, 8'h00, 1'b0, 1'b1, 8'hB7, "R1");
    access(0, 1'b0, 8'h10, 8'h00, 1'b1, 1'b1, 8'hB5, "R1");
    access(0, 1'b0, 8'h13, 8'h00, 1'b1, 1'b1, 8'hB6, "R1");
  endtask

  task automatic t_lru();
    access(0, 1'b0, 8'h20, 8'h00, 1'b0, 1'b1, 8'h85, "R5");
    access(0, 1'b0, 8'h10, 8'h00, 1'b1, 1'b1, 8'hB5, "R5");
    access(0, 1'b0, 8'h30, 8'h00, 1'b0, 1'b1, 8'h95, "R5");
    access(0, 1'b0, 8'h10, 8'h00, 1'b1, 1'b1, 8'hB5, "R5");
    access(0, 1'b0, 8'h20, 8'h00, 1'b0, 1'b1, 8'h85, "R5");
    access(0, 1'b0, 8'h10, 8'h00, 1'b1, 1'b1, 8'hB5, "R5");
  endtask

  task automatic t_wb_dirty();
    int w0 = wrc(0);
    access(0, 1'b1, 8'h10, 8'h5A, 1'b1, 1'b0, 8'h00, "R6");
    check("R6", "no write on hit", wrc(0) - w0, 0);
    access(0, 1'b0, 8'h10, 8'h00, 1'b1, 1'b1, 8'h5A, "R6");
    check("R6", "memory stale", memv(0, 'h10), 'hB5);
    access(0, 1'b0, 8'h30, 8'h00, 1'b0, 1'b1, 8'h95, "R6");
    check("R6", "clean eviction silent", wrc(0) - w0, 0);
    access(0, 1'b0, 8'h40, 8'h00, 1'b0, 1'b1, 8'hE5, "R6");
    check("R6", "dirty eviction writes", wrc(0) - w0, 1);
    check("R6", "written word", memv(0, 'h10), 'h5A);
    check("R6", "neighbour word", memv(0, 'h11), 'hB4);
    access(0, 1'b0, 8'h10, 8'h00, 1'b0, 1'b1, 8'h5A, "R6");
  endtask

  task automatic t_wb_alloc();
    int r0 = rdc(0);
    int w0 = wrc(0);
    access(0, 1'b1, 8'h52, 8'hC3, 1'b0, 1'b0, 8'h00, "R7");
    check("R7", "allocate read", rdc(0) - r0, 1);
    check("R7", "no memory write", wrc(0) - w0, 0);
    access(0, 1'b0, 8'h52, 8'h00, 1'b1, 1'b1, 8'hC3, "R7");
    access(0, 1'b0, 8'h53, 8'h00, 1'b1, 1'b1, 8'hF6, "R7");
    access(0, 1'b0, 8'h12, 8'h00, 1'b1, 1'b1, 8'hB7, "R7");
    check("R7", "memory untouched", memv(0, 'h52), 'hF7);
  endtask

  task automatic t_write_through();
    int w0;
    int r0;
    access(2, 1'b0, 8'h10, 8'h00, 1'b0, 1'b1, 8'hB5, "R3");
    w0 = wrc(2);
    access(2, 1'b1, 8'h10, 8'h77, 1'b1, 1'b0, 8'h00, "R8");
    check("R8", "write sent", wrc(2) - w0, 1);
    check("R8", "memory word", memv(2, 'h10), 'h77);
    check("R8", "strobe keeps neighbour", memv(2, 'h11), 'hB4);
    access(2, 1'b0, 8'h10, 8'h00, 1'b1, 1'b1, 8'h77, "R8");
    w0 = wrc(2);
    r0 = rdc(2);
    access(2, 1'b1, 8'h60, 8'h11, 1'b0, 1'b0, 8'h00, "R9");
    check("R9", "write sent", wrc(2) - w0, 1);
    check("R9", "no block read", rdc(2) - r0, 0);
    check("R9", "memory word", memv(2, 'h60), 'h11);
    access(2, 1'b0, 8'h60, 8'h00, 1'b0, 1'b1, 8'h11, "R9");
  endtask

  task automatic t_dm_trace();
    access(1, 1'b0, 8'd0,  8'h00, 1'b0, 1'b1, 8'hA5, "R4");
    access(1, 1'b0, 8'd1,  8'h00, 1'b1, 1'b1, 8'hA4, "R4");
    access(1, 1'b0, 8'd13, 8'h00, 1'b0, 1'b1, 8'hA8, "R4");
    access(1, 1'b0, 8'd8,  8'h00, 1'b0, 1'b1, 8'hAD, "R4");
    access(1, 1'b0, 8'd0,  8'h00, 1'b0, 1'b1, 8'hA5, "R4");
  endtask

  task automatic t_counters();
    repeat (4) @(negedge clk);
    for (int k = 0; k < 3; k++) begin
      check("R11", "total hits", int'(hc[k]), exp_h[k]);
      check("R11", "total misses", int'(mc[k]), exp_m[k]);
    end
  endtask

  task automatic t_reset_again();
    do_reset();
    check("R10", "hit_cnt cleared", int'(hc[0]), 0);
    check("R10", "miss_cnt cleared", int'(mc[0]), 0);
    access(0, 1'b0, 8'h10, 8'h00, 1'b0, 1'b1, 8'h5A, "R10");
    access(0, 1'b0, 8'h52, 8'h00, 1'b0, 1'b1, 8'hF7, "R10");
  endtask

  initial begin
    #(CLK_P * 200000);
    nfail++;
    $display("FAIL R12 watchdog actual=hung expected=done");
    $display("  TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

  initial begin
    for (int k = 0; k < 3; k++) begin
      req[k] = 1'b0; we_s[k] = 1'b0; addr_s[k] = '0; wd_s[k] = '0;
    end
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset_state();
    t_read_miss_hit();
    t_middle_index();
    t_lru();
    t_wb_dirty();
    t_wb_alloc();
    t_write_through();
    t_dm_trace();
    t_counters();
    t_reset_again();
    $display("  TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end
endmodule